// File: doc/BRIEF.md
# SIMD Square-Root Fault Check

This block decides which architectural fault a SIMD square-root instruction raises. It is used twice per instruction. Before execution, the issue logic pulses a check request with the control words, the processor capability word, the operating mode, the prefix flag and the operand description. The block then reports any undefined-opcode, device-not-available, general-protection, stack or alignment-check fault. After execution, the execution unit pulses a completion strobe with its unmasked-numeric-exception flag. The block then reports either a SIMD numeric fault or an undefined-opcode fault, depending on an operating-system control bit.

Only one fault is reported per result. It is the highest-priority one pending, shown both as a one-hot vector and as a small code. A completion is considered only for an instruction whose pre-execution check came back clean. Paging and the delivery of the exception are handled elsewhere.

Top module: `sqrt_fault_chk`

## Requirements
- R1: A check reports undefined-opcode when `ctl0_word` bit 2 is 1, when `ctl4_word` bit 9 is 0, or when `lock_pfx` is 1.
- R2: A check reports undefined-opcode when the capability bit for the precision is 0: bit 26 of `cap_word` when `op_double`=1, and bit 25 when `op_double`=0.
- R3: A check reports device-not-available when `ctl0_word` bit 3 is 1.
- R4: A packed form (`op_packed`=1) with a memory operand reports general-protection when `eff_addr[3:0]` is nonzero, in every mode. A register operand (`src_is_mem`=0) raises no address, alignment, segment or canonical fault.
- R5: A scalar memory form never faults for 16-byte misalignment. It reports alignment-check when all of the following hold: `align_chk_en`=1, the address is not a multiple of the operand size (8 bytes when `op_double`=1, 4 bytes otherwise), and the mode allows it. The modes that allow it are virtual-8086 mode, and protected or 64-bit mode with `cpl`=3. Real mode never reports it.
- R6: In real mode (`op_mode`=0) and virtual-8086 mode (`op_mode`=1), a memory operand reports general-protection when its last byte (`eff_addr` plus operand size minus 1, the size being 16, 8 or 4) lies above FFFFh.
- R7: In protected mode (`op_mode`=2), `seg_limit_viol` reports a stack fault when `seg_is_stack`=1 and general-protection otherwise. In 64-bit mode (`op_mode`=3), `addr_noncanon` does the same, and `seg_limit_viol` is ignored.
- R8: The fault vector bits are 0 undefined-opcode, 1 device-not-available, 2 general-protection, 3 stack, 4 alignment-check and 5 SIMD numeric. A lower index has higher priority. Only the winning bit is set, and `fault_code` is the bit index plus 1, with 0 meaning no fault.
- R9: One cycle after `chk_valid`, `rpt_valid` is 1 and the vector and code hold the check result. A clean check arms the completion.
- R10: `exe_done` on an armed instruction reports after one cycle and disarms it. The report is a SIMD numeric fault if `exe_unmasked`=1 and `ctl4_word` bit 10 is 1, undefined-opcode if `exe_unmasked`=1 and bit 10 is 0, and no fault if `exe_unmasked`=0.
- R11: `exe_done` with nothing armed is ignored: `rpt_valid` stays 0 and the vector and code hold. When `chk_valid` and `exe_done` arrive together, the check is served and the completion is dropped.
- R12: After reset, `rpt_valid`, `fault_vec` and `fault_code` are 0 and nothing is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | Pre-execution check request |
| ctl0_word | input | 32 | Control word with the emulation (bit 2) and task-switched (bit 3) bits |
| ctl4_word | input | 32 | Control word with the OS extended-state (bit 9) and OS numeric-trap (bit 10) bits |
| cap_word | input | 32 | Processor capability word (bits 25 and 26) |
| op_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected or compatibility, 3 64-bit |
| lock_pfx | input | 1 | Bus-lock prefix present |
| src_is_mem | input | 1 | Source is a memory operand |
| op_packed | input | 1 | 1 packed 16-byte form, 0 scalar form |
| op_double | input | 1 | 1 double precision, 0 single precision |
| eff_addr | input | 64 | Effective address or offset of the memory operand |
| cpl | input | 2 | Current privilege level |
| align_chk_en | input | 1 | Alignment checking enabled |
| seg_limit_viol | input | 1 | Segment unit reports a limit or access violation |
| seg_is_stack | input | 1 | Reference uses the stack segment |
| addr_noncanon | input | 1 | Address is not in canonical form |
| exe_done | input | 1 | Execution of the instruction has completed |
| exe_unmasked | input | 1 | Execution raised an unmasked numeric exception |
| rpt_valid | output | 1 | A result was produced in the previous cycle |
| fault_vec | output | 6 | One-hot winning fault |
| fault_code | output | 3 | Encoded winning fault |

## Verification
The main sweep covers every operating mode with both widths, both precisions, register and memory operands, and privilege levels 0 and 3. It also toggles the alignment-check enable, segment violation, stack selection and canonical status, over addresses that are aligned, 4- or 8-byte misaligned, or at the top of the 64 KiB window. This separates the packed alignment rule from the scalar alignment-check rule, and the real-mode window from the protected and 64-bit address checks. A second sweep walks all combinations of the control, capability and prefix bits against a misaligned packed access, which exposes the priority order. Completion sequences combine the trap bit with the numeric flag, and exercise completions after a faulted check, repeated completions and a completion that collides with a check.

// File: rtl/sqft_pkg.sv
package sqft_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } op_mode_e;

  // Fault vector layout; the index is also the priority (0 wins).
  localparam int unsigned NUM_FAULTS = 6;
  localparam int unsigned FIDX_UD    = 0;
  localparam int unsigned FIDX_NM    = 1;
  localparam int unsigned FIDX_GP    = 2;
  localparam int unsigned FIDX_SS    = 3;
  localparam int unsigned FIDX_AC    = 4;
  localparam int unsigned FIDX_XM    = 5;
  localparam int unsigned CODE_W     = $clog2(NUM_FAULTS + 1);

  typedef logic [NUM_FAULTS-1:0] fault_vec_t;
  typedef logic [CODE_W-1:0]     fault_code_t;

endpackage

// File: rtl/sqft_pre_decode.sv
// Instruction-enable checks that do not depend on the operand address.
module sqft_pre_decode (
  input  logic emu_on,
  input  logic ts_on,
  input  logic os_ext_on,
  input  logic cap_dp,
  input  logic cap_sp,
  input  logic lock_pfx,
  input  logic op_double,
  output logic ud_hit,
  output logic nm_hit
);

  logic cap_missing;

  always_comb begin
    cap_missing = op_double ? ~cap_dp : ~cap_sp;
    ud_hit      = emu_on | ~os_ext_on | lock_pfx | cap_missing;
    nm_hit      = ts_on;
  end

endmodule

// File: rtl/sqft_mem_check.sv
// Address-dependent checks: packed alignment, real-mode window,
// segment and canonical status, scalar alignment check.
module sqft_mem_check
  import sqft_pkg::*;
#(
  parameter int unsigned AW        = 64,
  parameter int unsigned VEC_BYTES = 16,
  parameter int unsigned DBL_BYTES = 8,
  parameter int unsigned SGL_BYTES = 4,
  parameter int unsigned WIN_BITS  = 16
) (
  input  op_mode_e        mode,
  input  logic            src_is_mem,
  input  logic            op_packed,
  input  logic            op_double,
  input  logic [AW-1:0]   eff_addr,
  input  logic [1:0]      cpl,
  input  logic            align_chk_en,
  input  logic            seg_limit_viol,
  input  logic            seg_is_stack,
  input  logic            addr_noncanon,
  output logic            gp_hit,
  output logic            ss_hit,
  output logic            ac_hit
);

  localparam int unsigned LG = $clog2(VEC_BYTES);
  localparam logic [AW:0] SZM_VEC = (AW+1)'(VEC_BYTES - 1);
  localparam logic [AW:0] SZM_DBL = (AW+1)'(DBL_BYTES - 1);
  localparam logic [AW:0] SZM_SGL = (AW+1)'(SGL_BYTES - 1);

  logic [AW:0] size_m1;
  logic [AW:0] last_byte;
  logic        misalign;
  logic        win_over;
  logic        real_like;
  logic        prot_seg;
  logic        long_adr;
  logic        ac_mode_ok;

  always_comb begin
    size_m1    = op_packed ? SZM_VEC : (op_double ? SZM_DBL : SZM_SGL);
    last_byte  = {1'b0, eff_addr} + size_m1;
    misalign   = |(eff_addr[LG-1:0] & size_m1[LG-1:0]);
    win_over   = |last_byte[AW:WIN_BITS];
    real_like  = (mode == MODE_REAL) || (mode == MODE_V86);
    prot_seg   = (mode == MODE_PROT) && seg_limit_viol;
    long_adr   = (mode == MODE_LONG) && addr_noncanon;
    ac_mode_ok = (mode == MODE_V86) ||
                 (((mode == MODE_PROT) || (mode == MODE_LONG)) && (cpl == 2'd3));

    gp_hit = src_is_mem & ((op_packed & misalign) |
                           (real_like & win_over) |
                           ((prot_seg | long_adr) & ~seg_is_stack));
    ss_hit = src_is_mem & (prot_seg | long_adr) & seg_is_stack;
    ac_hit = src_is_mem & ~op_packed & misalign & align_chk_en & ac_mode_ok;
  end

endmodule

// File: rtl/sqft_prio_pick.sv
// Fixed-priority picker: lowest index wins; code is index + 1.
module sqft_prio_pick #(
  parameter int unsigned N  = 6,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [CW-1:0] code
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < N; gi++) begin : g_pick
    assign grant[gi]  = req[gi] & ~seen[gi];
    assign seen[gi+1] = seen[gi] | req[gi];
  end

  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = CW'(i + 1);
    end
  end

endmodule

// File: rtl/sqrt_fault_chk.sv
module sqrt_fault_chk
  import sqft_pkg::*;
#(
  parameter int unsigned CTL_W       = 32,
  parameter int unsigned CAP_W       = 32,
  parameter int unsigned AW          = 64,
  parameter int unsigned EMU_BIT     = 2,
  parameter int unsigned TS_BIT      = 3,
  parameter int unsigned OS_EXT_BIT  = 9,
  parameter int unsigned OS_TRAP_BIT = 10,
  parameter int unsigned CAP_SP_BIT  = 25,
  parameter int unsigned CAP_DP_BIT  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [CTL_W-1:0]  ctl0_word,
  input  logic [CTL_W-1:0]  ctl4_word,
  input  logic [CAP_W-1:0]  cap_word,
  input  logic [1:0]        op_mode,
  input  logic              lock_pfx,
  input  logic              src_is_mem,
  input  logic              op_packed,
  input  logic              op_double,
  input  logic [AW-1:0]     eff_addr,
  input  logic [1:0]        cpl,
  input  logic              align_chk_en,
  input  logic              seg_limit_viol,
  input  logic              seg_is_stack,
  input  logic              addr_noncanon,
  input  logic              exe_done,
  input  logic              exe_unmasked,
  output logic              rpt_valid,
  output logic [NUM_FAULTS-1:0] fault_vec,
  output logic [CODE_W-1:0]     fault_code
);

  op_mode_e    mode;
  logic        ud_hit, nm_hit, gp_hit, ss_hit, ac_hit;
  logic        trap_on;
  fault_vec_t  pre_req, post_req, sel_req, grant;
  fault_code_t grant_code;

  logic        take_chk, take_done;
  logic        rpt_d, rpt_q;
  logic        pend_d, pend_q;
  fault_vec_t  vec_q;
  fault_code_t code_q;
  logic        unused_bits;

  assign mode        = op_mode_e'(op_mode);
  assign trap_on     = ctl4_word[OS_TRAP_BIT];
  assign unused_bits = ^{ctl0_word, ctl4_word, cap_word};

  sqft_pre_decode u_pre (
    .emu_on    (ctl0_word[EMU_BIT]),
    .ts_on     (ctl0_word[TS_BIT]),
    .os_ext_on (ctl4_word[OS_EXT_BIT]),
    .cap_dp    (cap_word[CAP_DP_BIT]),
    .cap_sp    (cap_word[CAP_SP_BIT]),
    .lock_pfx  (lock_pfx),
    .op_double (op_double),
    .ud_hit    (ud_hit),
    .nm_hit    (nm_hit)
  );

  sqft_mem_check #(.AW(AW)) u_mem (
    .mode           (mode),
    .src_is_mem     (src_is_mem),
    .op_packed      (op_packed),
    .op_double      (op_double),
    .eff_addr       (eff_addr),
    .cpl            (cpl),
    .align_chk_en   (align_chk_en),
    .seg_limit_viol (seg_limit_viol),
    .seg_is_stack   (seg_is_stack),
    .addr_noncanon  (addr_noncanon),
    .gp_hit         (gp_hit),
    .ss_hit         (ss_hit),
    .ac_hit         (ac_hit)
  );

  // Request assembly: pre-execution faults vs. post-execution numeric faults.
  always_comb begin
    pre_req           = '0;
    pre_req[FIDX_UD]  = ud_hit;
    pre_req[FIDX_NM]  = nm_hit;
    pre_req[FIDX_GP]  = gp_hit;
    pre_req[FIDX_SS]  = ss_hit;
    pre_req[FIDX_AC]  = ac_hit;

    post_req          = '0;
    post_req[FIDX_UD] = exe_unmasked & ~trap_on;
    post_req[FIDX_XM] = exe_unmasked &  trap_on;

    sel_req = chk_valid ? pre_req : post_req;
  end

  sqft_prio_pick #(.N(NUM_FAULTS)) u_pick (
    .req   (sel_req),
    .grant (grant),
    .code  (grant_code)
  );

  // Next state
  always_comb begin
    take_chk  = chk_valid;
    take_done = exe_done & ~chk_valid & pend_q;
    rpt_d     = take_chk | take_done;
    if (take_chk)       pend_d = (grant == '0);
    else if (take_done) pend_d = 1'b0;
    else                pend_d = pend_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      rpt_q  <= rpt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      code_q <= '0;
    end else if (rpt_d) begin
      vec_q  <= grant;
      code_q <= grant_code;
    end
  end

  assign rpt_valid  = rpt_q;
  assign fault_vec  = vec_q;
  assign fault_code = code_q;

  // Assertions
  a_r8_onehot_vec: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_q));

  a_r1_lock_ud: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && lock_pfx |=> vec_q[FIDX_UD] && code_q == CODE_W'(FIDX_UD + 1));

  a_r3_ts_nm: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && ctl0_word[TS_BIT] && !lock_pfx && !ctl0_word[EMU_BIT] &&
    ctl4_word[OS_EXT_BIT] &&
    (op_double ? cap_word[CAP_DP_BIT] : cap_word[CAP_SP_BIT])
    |=> vec_q[FIDX_NM]);

  a_r9_rpt_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rpt_q);

  a_r10_trap_xm: assert property (@(posedge clk) disable iff (!rst_n)
    exe_done && !chk_valid && pend_q && exe_unmasked && trap_on
    |=> rpt_q && code_q == CODE_W'(FIDX_XM + 1) && !pend_q);

  a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    exe_done && !chk_valid && !pend_q |=> !rpt_q && $stable(vec_q) && $stable(code_q));

endmodule

// File: tb/tb_sqrt_fault_chk.sv
`timescale 1ns/100ps
module tb_sqrt_fault_chk;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_valid, lock_pfx, src_is_mem, op_packed, op_double;
  logic [31:0] ctl0_word, ctl4_word, cap_word;
  logic [1:0]  op_mode, cpl;
  logic [63:0] eff_addr;
  logic        align_chk_en, seg_limit_viol, seg_is_stack, addr_noncanon;
  logic        exe_done, exe_unmasked;
  logic        rpt_valid;
  logic [5:0]  fault_vec;
  logic [2:0]  fault_code;

  int n_chk  = 0;
  int n_fail = 0;
  int   exp_idx;
  string exp_tag;

  always #2.5 clk = ~clk;

  sqrt_fault_chk dut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid),
    .ctl0_word(ctl0_word), .ctl4_word(ctl4_word), .cap_word(cap_word),
    .op_mode(op_mode), .lock_pfx(lock_pfx), .src_is_mem(src_is_mem),
    .op_packed(op_packed), .op_double(op_double), .eff_addr(eff_addr),
    .cpl(cpl), .align_chk_en(align_chk_en), .seg_limit_viol(seg_limit_viol),
    .seg_is_stack(seg_is_stack), .addr_noncanon(addr_noncanon),
    .exe_done(exe_done), .exe_unmasked(exe_unmasked),
    .rpt_valid(rpt_valid), .fault_vec(fault_vec), .fault_code(fault_code)
  );

  // Expected pre-execution fault from the requirements.
  function automatic void expect_pre();
    int          sz;
    logic [64:0] last;
    logic ud_cap, ud_ctl, nm, gp_al, gp_win, gp_seg, ss, ac;
    int          cnt;
    sz     = op_packed ? 16 : (op_double ? 8 : 4);
    last   = {1'b0, eff_addr} + 65'(sz - 1);
    ud_ctl = ctl0_word[2] | ~ctl4_word[9] | lock_pfx;
    ud_cap = op_double ? ~cap_word[26] : ~cap_word[25];
    nm     = ctl0_word[3];
    gp_al  = src_is_mem && op_packed && (eff_addr % 16 != 0);
    gp_win = src_is_mem && (op_mode < 2) && (last > 65'h0FFFF);
    gp_seg = 1'b0; ss = 1'b0;
    if (src_is_mem && ((op_mode == 2 && seg_limit_viol) || (op_mode == 3 && addr_noncanon))) begin
      if (seg_is_stack) ss = 1'b1; else gp_seg = 1'b1;
    end
    ac = src_is_mem && !op_packed && align_chk_en && (eff_addr % 64'(sz) != 0) &&
         (op_mode == 1 || (op_mode >= 2 && cpl == 2'd3));
    cnt = int'(ud_ctl | ud_cap) + int'(nm) + int'(gp_al | gp_win | gp_seg) + int'(ss) + int'(ac);
    if (ud_ctl | ud_cap) begin exp_idx = 0; exp_tag = ud_ctl ? "R1" : "R2"; end
    else if (nm)         begin exp_idx = 1; exp_tag = "R3"; end
    else if (gp_al)      begin exp_idx = 2; exp_tag = "R4"; end
    else if (gp_win)     begin exp_idx = 2; exp_tag = "R6"; end
    else if (gp_seg)     begin exp_idx = 2; exp_tag = "R7"; end
    else if (ss)         begin exp_idx = 3; exp_tag = "R7"; end
    else if (ac)         begin exp_idx = 4; exp_tag = "R5"; end
    else                 begin exp_idx = -1; exp_tag = "R9"; end
    if (cnt > 1) exp_tag = "R8";
  endfunction

  task automatic compare(input logic erv, input int idx, input string tag);
    logic [5:0] ev;
    logic [2:0] ec;
    ev = (idx < 0) ? 6'd0 : 6'(1 << idx);
    ec = (idx < 0) ? 3'd0 : 3'(idx + 1);
    n_chk++;
    if (rpt_valid !== erv || fault_vec !== ev || fault_code !== ec) begin
      n_fail++;
      $display("FAIL %s: got rv=%b vec=%b code=%0d, expected rv=%b vec=%b code=%0d",
               tag, rpt_valid, fault_vec, fault_code, erv, ev, ec);
    end
  endtask

  task automatic run_chk();
    @(negedge clk);
    chk_valid = 1'b1;
    expect_pre();
    @(negedge clk);
    chk_valid = 1'b0;
    compare(1'b1, exp_idx, exp_tag);
  endtask

  task automatic run_done(input logic unm, input logic erv, input int idx, input string tag);
    @(negedge clk);
    exe_done = 1'b1; exe_unmasked = unm;
    @(negedge clk);
    exe_done = 1'b0; exe_unmasked = 1'b0;
    compare(erv, idx, tag);
  endtask

  task automatic base_setup();
    ctl0_word = 32'h0; ctl4_word = 32'h0000_0600; cap_word = 32'h0600_0000;
    op_mode = 2'd2; lock_pfx = 1'b0; src_is_mem = 1'b0; op_packed = 1'b1;
    op_double = 1'b1; eff_addr = 64'h0; cpl = 2'd0; align_chk_en = 1'b0;
    seg_limit_viol = 1'b0; seg_is_stack = 1'b0; addr_noncanon = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] addrs [8];
    addrs = '{64'h0, 64'h4, 64'h8, 64'h3, 64'hFFF0, 64'hFFF8, 64'hFFFC, 64'h1_0000};
    rst_n = 1'b0; chk_valid = 1'b0; exe_done = 1'b0; exe_unmasked = 1'b0;
    base_setup();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(1'b0, -1, "R12");               // R12 reset state
    run_done(1'b1, 1'b0, -1, "R12");        // R12 nothing armed after reset

    // Operand / mode sweep (R4..R8)
    for (int m = 0; m < 4; m++)
      for (int pk = 0; pk < 2; pk++)
        for (int db = 0; db < 2; db++)
          for (int mem = 0; mem < 2; mem++)
            for (int a = 0; a < 8; a++)
              for (int pl = 0; pl < 2; pl++)
                for (int ace = 0; ace < 2; ace++)
                  for (int sv = 0; sv < 2; sv++)
                    for (int st = 0; st < 2; st++)
                      for (int nc = 0; nc < 2; nc++) begin
                        op_mode = 2'(m); op_packed = pk[0]; op_double = db[0];
                        src_is_mem = mem[0]; eff_addr = addrs[a];
                        cpl = pl[0] ? 2'd3 : 2'd0; align_chk_en = ace[0];
                        seg_limit_viol = sv[0]; seg_is_stack = st[0];
                        addr_noncanon = nc[0];
                        run_chk();
                      end

    // Control / capability / prefix sweep (R1, R2, R3, R8)
    base_setup();
    src_is_mem = 1'b1; eff_addr = 64'h8;
    for (int c = 0; c < 64; c++)
      for (int db = 0; db < 2; db++) begin
        ctl0_word = {28'h0, c[3], c[2], 2'b00};
        ctl4_word = {21'h0, 1'b1, c[4], 9'h0};
        lock_pfx  = c[5];
        cap_word  = {5'h0, c[1], c[0], 25'h0};
        op_double = db[0];
        run_chk();
      end

    // Completion handling (R10)
    base_setup();
    for (int tr = 0; tr < 2; tr++)
      for (int un = 0; un < 2; un++) begin
        ctl4_word = {21'h0, tr[0], 1'b1, 9'h0};
        run_chk();                           // clean check arms
        run_done(un[0], 1'b1, un[0] ? (tr[0] ? 5 : 0) : -1, "R10");
      end

    // Ignored completions (R11)
    base_setup();
    ctl4_word = 32'h0000_0600;
    run_chk();
    run_done(1'b0, 1'b1, -1, "R10");
    run_done(1'b1, 1'b0, -1, "R11");         // second completion: no one armed
    lock_pfx = 1'b1;
    run_chk();                               // faulted check: UD, not armed
    lock_pfx = 1'b0;
    run_done(1'b1, 1'b0, 0, "R11");          // held UD, no report
    // Collision: check served, completion dropped
    run_chk();                               // clean, armed
    @(negedge clk);
    chk_valid = 1'b1; exe_done = 1'b1; exe_unmasked = 1'b1;
    ctl0_word = 32'h8;                       // NM for the new check
    @(negedge clk);
    chk_valid = 1'b0; exe_done = 1'b0; exe_unmasked = 1'b0;
    compare(1'b1, 1, "R11");
    ctl0_word = 32'h0;
    run_done(1'b1, 1'b0, 1, "R11");          // NM check disarmed; hold

    finish_run();
  end

endmodule